// File: doc/BRIEF.md
# Dual-Control Up/Down Binary Counter

This block is a small synchronous binary counter whose direction is chosen by two independent control lines rather than one direction select. One line requests an increment and the other a decrement. With neither line active the count rests. Raising both at once is a forbidden request. The counter then keeps its value and raises an error flag for as long as the combination is present.

Each state bit is a D-type register. Its next value is the present value exclusive-ORed with a toggle condition. Bit 0 toggles whenever either control line is active. Any higher bit toggles when counting up with every lower bit at 1, or when counting down with every lower bit at 0. The count therefore wraps in both directions.

An active-low clear forces the count to zero at once, without waiting for a clock edge. Its release passes through a two-stage synchronizer, so counting resumes only on the third rising clock edge after the clear input goes high.

Top module: `dual_ctl_counter`

## Requirements
- R1: With the up line at 1 and the down line at 0, the count increases by one on each rising clock edge, and 7 is followed by 0.
- R2: With the up line at 0 and the down line at 1, the count decreases by one on each rising clock edge, and 0 is followed by 7.
- R3: With both control lines at 0, the count keeps its value across clock edges.
- R4: With both control lines at 1, the count keeps its value and the error flag is 1. In every other combination the error flag is 0. The flag follows the control lines without waiting for a clock edge.
- R5: While the clear input is 0, the count reads 0 immediately, with no clock edge needed.
- R6: After the clear input rises, the first two rising clock edges leave the count at 0 whatever the control lines request. The third rising edge is the first one that counts.
- R7: Each bit above bit 0 flips only when every lower bit is 1 while counting up, or every lower bit is 0 while counting down. Bit 0 flips whenever exactly one control line is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count changes on its rising edge |
| rst_n | input | 1 | Active-low clear: asserts at once, release is synchronized |
| cnt_up_i | input | 1 | Increment request |
| cnt_dn_i | input | 1 | Decrement request |
| count_o | output | 3 | Present count value |
| ctl_err_o | output | 1 | High while both requests are active together |

## Verification
The assertions take for granted that the control lines are stable around each rising clock edge. They also assume that the clear input is the only source of a change outside the count sequence.

The bench changes the control lines only on falling edges and releases the clear on a falling edge. This keeps every request settled a half period before the edge that acts on it. The forbidden combination is applied on purpose, so the hold-and-flag behaviour in R4 is observed. The clear is also asserted between edges, so R5 can be checked while no clock edge occurs.

// File: rtl/dual_ctl_counter_pkg.sv
package dual_ctl_counter_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_DOWN = 2'b01,
    MODE_UP   = 2'b10,
    MODE_BAD  = 2'b11
  } cnt_mode_e;

endpackage

// File: rtl/dual_ctl_counter_rst_sync.sv
module dual_ctl_counter_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/dual_ctl_counter_decode.sv
module dual_ctl_counter_decode
  import dual_ctl_counter_pkg::*;
(
  input  logic      up_req,
  input  logic      dn_req,
  output cnt_mode_e mode,
  output logic      bad_ctl
);

  always_comb begin
    unique case ({up_req, dn_req})
      2'b10:   mode = MODE_UP;
      2'b01:   mode = MODE_DOWN;
      2'b11:   mode = MODE_BAD;
      default: mode = MODE_HOLD;
    endcase
  end

  assign bad_ctl = (mode == MODE_BAD);

endmodule

// File: rtl/dual_ctl_counter_toggle.sv
module dual_ctl_counter_toggle #(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             go_up,
  input  logic             go_dn,
  output logic [WIDTH-1:0] flip
);

  // all_hi[i]: bits below i all one; all_lo[i]: bits below i all zero
  logic [WIDTH:0] all_hi;
  logic [WIDTH:0] all_lo;

  assign all_hi[0] = 1'b1;
  assign all_lo[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign all_hi[i+1] = all_hi[i] & cur[i];
    assign all_lo[i+1] = all_lo[i] & ~cur[i];
    assign flip[i]     = (go_up & all_hi[i]) | (go_dn & all_lo[i]);
  end

endmodule

// File: rtl/dual_ctl_counter.sv
module dual_ctl_counter
  import dual_ctl_counter_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_up_i,
  input  logic             cnt_dn_i,
  output logic [WIDTH-1:0] count_o,
  output logic             ctl_err_o
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic             srst_n;
  cnt_mode_e        mode;
  logic             go_up;
  logic             go_dn;
  logic             cnt_en;
  logic [WIDTH-1:0] flip;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  dual_ctl_counter_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dual_ctl_counter_decode u_decode (
    .up_req  (cnt_up_i),
    .dn_req  (cnt_dn_i),
    .mode    (mode),
    .bad_ctl (ctl_err_o)
  );

  assign go_up  = (mode == MODE_UP);
  assign go_dn  = (mode == MODE_DOWN);
  assign cnt_en = go_up | go_dn;

  dual_ctl_counter_toggle #(.WIDTH(WIDTH)) u_toggle (
    .cur   (cnt_q),
    .go_up (go_up),
    .go_dn (go_dn),
    .flip  (flip)
  );

  always_comb begin
    cnt_d = cnt_q ^ flip;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

  // R1
  up_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (cnt_up_i && !cnt_dn_i) |=> (count_o == $past(count_o) + ONE));

  // R2
  dn_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!cnt_up_i && cnt_dn_i) |=> (count_o == $past(count_o) - ONE));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!cnt_up_i && !cnt_dn_i) |=> $stable(count_o));

  // R4
  bad_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ctl_err_o |=> $stable(count_o));

  // R4
  bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_err_o == (cnt_up_i && cnt_dn_i));

  // R5
  always @(posedge clk) begin
    if (!rst_n) begin
      clr_zero_chk: assert (count_o == '0);
    end
  end

  // R6
  rel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_n |=> (count_o == '0));

  // R7
  lsb_flip_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (cnt_up_i ^ cnt_dn_i) |=> (count_o[0] != $past(count_o[0])));

endmodule

// File: tb/dual_ctl_counter_tb.sv
module dual_ctl_counter_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       up;
  logic       dn;
  logic [2:0] count;
  logic       err;

  int checks = 0;
  int errors = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic [2:0] model = '0;
  int         rel = 0;

  always #5 clk = ~clk;

  dual_ctl_counter u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_up_i  (up),
    .cnt_dn_i  (dn),
    .count_o   (count),
    .ctl_err_o (err)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compare each edge's result against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        check(tag_q.pop_front(), count, exp_q.pop_front());
      end
    end
  end

  // driver: apply controls, predict the next count and push it
  task automatic step(input logic u, input logic d, input string req);
    @(negedge clk);
    up = u;
    dn = d;
    #1;
    check("R4 flag", {2'b0, err}, {2'b0, u & d});
    if (rel >= 2) begin
      if (u && !d)      model = model + 3'd1;
      else if (!u && d) model = model - 3'd1;
    end else begin
      req = "R6";
    end
    rel++;
    exp_q.push_back(model);
    tag_q.push_back(req);
  endtask

  task automatic release_clr();
    @(negedge clk);
    up = 1'b0;
    dn = 1'b0;
    rst_n = 1'b1;
    model = '0;
    rel = 1;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    up = 1'b0;
    dn = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R5 reset", count, 3'd0);
    release_clr();
    // R6 then R1 with wrap 7 -> 0, R7 carries
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, "R1");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R3");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R4");
    // R2 with wrap 0 -> 7, R7 borrows
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b0, "R3");
    step(1'b1, 1'b0, "R7");
    step(1'b0, 1'b1, "R7");
    @(negedge clk);
    up = 1'b0;
    dn = 1'b0;
    repeat (2) @(posedge clk);
    check("R5 pre", count, model);
    #3;
    rst_n = 1'b0;
    #1;
    check("R5 async", count, 3'd0);
    repeat (2) @(posedge clk);
    release_clr();
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R2");
    step(1'b1, 1'b1, "R4");
    step(1'b1, 1'b0, "R1");
    @(negedge clk);
    up = 1'b0;
    dn = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule